// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block sits on a microprocessor's bus and gives it three 8-bit parallel ports, A, B and C. The host reaches four registers through an 8-bit data bus, two address bits, an active-low chip select and active-low read and write strobes. Three of the registers hold port data. The fourth takes control words.

A control word with its top bit set sets the direction of ports A and B and of each half of port C. Writing such a word also clears every output latch, so a port that becomes an output starts from zero. A control word with its top bit clear sets or clears one port C latch bit and leaves the other seven bits as they were.

Pins are not modelled as tristate pads. Each port has a pin input bus, a latched output bus and an output-enable bus, one enable per bit. Only basic input/output operation is built. Mode-select fields for strobed and bidirectional operation are accepted and then ignored.

Top module: `pport_top`

## Requirements
- R1: After reset every output-enable bit is 0 (all ports are inputs), and pa_o, pb_o and pc_o are all 0.
- R2: addr_i selects the register: 0 is port A, 1 is port B, 2 is port C and 3 is control. While cs_ni is high, writes change no output and data_o reads 0.
- R3: A control write with data bit 7 = 1 sets the directions: bit 4 for port A, bit 1 for port B, bit 3 for C[7:4] and bit 0 for C[3:0]. A value of 1 means input. Every output-enable bit of an output group is 1 and every output-enable bit of an input group is 0, from the cycle after the write.
- R4: A control write with bit 7 = 1 clears pa_o, pb_o and pc_o to 0 in the cycle after the write.
- R5: A data write to port A, B or C loads that port's latch, which is visible on its _o bus in the cycle after the write. The value stays there until the next write that changes it.
- R6: A read of a port, or of a port C half, that is set as input returns the pin inputs combinationally, in the same cycle, with no latch.
- R7: A read of a port that is set as output returns its latch value.
- R8: A port C read returns latch bits for the output half and pin bits for the input half, for each half separately.
- R9: A control write with bit 7 = 0 sets pc_o bit data[3:1] to data[0], in the cycle after the write. The other seven bits keep their values.
- R10: A read of the control address returns 0. data_o is 0 whenever rd_ni or cs_ni is high.
- R11: Mode-word bits 6:5 and 2 have no effect on direction, latches or reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low, sampled on the clock edge |
| addr_i | input | 2 | Register select |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C output enables |

## Verification
Writes are sampled on the rising clock edge. Latches, enables and set/reset results therefore appear one cycle after the write, and the bench compares all _o and _oe_o buses with its model at the falling edge that follows. Reads have no register on the path, so the result is due in the same cycle. The bench drives the address, strobes and pins at a falling edge, waits a short delay, and samples data_o before the next rising edge. Pins change at random before every operation, which shows whether a read returns live pin values or a stale capture.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PW   = 8;
  localparam int IDXW = $clog2(PW);
  localparam int HW   = PW / 2;

  // control word fields
  localparam int CW_MODE = 7;
  localparam int CW_A    = 4;
  localparam int CW_CU   = 3;
  localparam int CW_B    = 1;
  localparam int CW_CL   = 0;

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;

  // 1 = input
  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_t;
endpackage

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  sel_e          sel_i,
  input  logic [PW-1:0] wdata_i,
  output dir_t          dir_o,
  output logic [PW-1:0] pa_q_o,
  output logic [PW-1:0] pb_q_o,
  output logic [PW-1:0] pc_q_o
);
  logic mode_wr, bsr_wr;
  assign mode_wr = wr_en_i && (sel_i == SEL_CTL) && wdata_i[CW_MODE];
  assign bsr_wr  = wr_en_i && (sel_i == SEL_CTL) && !wdata_i[CW_MODE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
    end else if (mode_wr) begin
      dir_o <= '{a_in: wdata_i[CW_A], b_in: wdata_i[CW_B],
                 cu_in: wdata_i[CW_CU], cl_in: wdata_i[CW_CL]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q_o <= '0;
      pb_q_o <= '0;
    end else if (mode_wr) begin
      pa_q_o <= '0;
      pb_q_o <= '0;
    end else if (wr_en_i) begin
      if (sel_i == SEL_A) pa_q_o <= wdata_i;
      if (sel_i == SEL_B) pb_q_o <= wdata_i;
    end
  end

  // port C: per-bit latch, loaded by data write or single-bit set/reset
  for (genvar i = 0; i < PW; i++) begin : g_pc_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pc_q_o[i] <= 1'b0;
      end else if (mode_wr) begin
        pc_q_o[i] <= 1'b0;
      end else if (bsr_wr && (wdata_i[IDXW:1] == IDXW'(i))) begin
        pc_q_o[i] <= wdata_i[0];
      end else if (wr_en_i && (sel_i == SEL_C)) begin
        pc_q_o[i] <= wdata_i[i];
      end
    end
  end
endmodule

// File: rtl/pport_rdmux.sv
module pport_rdmux
  import pport_pkg::*;
(
  input  logic          rd_en_i,
  input  sel_e          sel_i,
  input  dir_t          dir_i,
  input  logic [PW-1:0] pa_q_i,
  input  logic [PW-1:0] pb_q_i,
  input  logic [PW-1:0] pc_q_i,
  input  logic [PW-1:0] pa_pin_i,
  input  logic [PW-1:0] pb_pin_i,
  input  logic [PW-1:0] pc_pin_i,
  output logic [PW-1:0] rdata_o
);
  logic [PW-1:0] pa_view, pb_view, pc_view;

  assign pa_view = dir_i.a_in ? pa_pin_i : pa_q_i;
  assign pb_view = dir_i.b_in ? pb_pin_i : pb_q_i;
  assign pc_view = {dir_i.cu_in ? pc_pin_i[PW-1:HW] : pc_q_i[PW-1:HW],
                    dir_i.cl_in ? pc_pin_i[HW-1:0]  : pc_q_i[HW-1:0]};

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (sel_i)
        SEL_A:   rdata_o = pa_view;
        SEL_B:   rdata_o = pb_view;
        SEL_C:   rdata_o = pc_view;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pport_top.sv
module pport_top
  import pport_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [1:0]    addr_i,
  input  logic [PW-1:0] data_i,
  output logic [PW-1:0] data_o,
  input  logic [PW-1:0] pa_i,
  output logic [PW-1:0] pa_o,
  output logic [PW-1:0] pa_oe_o,
  input  logic [PW-1:0] pb_i,
  output logic [PW-1:0] pb_o,
  output logic [PW-1:0] pb_oe_o,
  input  logic [PW-1:0] pc_i,
  output logic [PW-1:0] pc_o,
  output logic [PW-1:0] pc_oe_o
);
  sel_e sel;
  dir_t dir;
  logic wr_en, rd_en;

  assign sel   = sel_e'(addr_i);
  assign wr_en = !cs_ni && !wr_ni;
  assign rd_en = !cs_ni && !rd_ni;

  pport_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .sel_i   (sel),
    .wdata_i (data_i),
    .dir_o   (dir),
    .pa_q_o  (pa_o),
    .pb_q_o  (pb_o),
    .pc_q_o  (pc_o)
  );

  pport_rdmux u_rdmux (
    .rd_en_i  (rd_en),
    .sel_i    (sel),
    .dir_i    (dir),
    .pa_q_i   (pa_o),
    .pb_q_i   (pb_o),
    .pc_q_i   (pc_o),
    .pa_pin_i (pa_i),
    .pb_pin_i (pb_i),
    .pc_pin_i (pc_i),
    .rdata_o  (data_o)
  );

  assign pa_oe_o = {PW{!dir.a_in}};
  assign pb_oe_o = {PW{!dir.b_in}};
  assign pc_oe_o = {{HW{!dir.cu_in}}, {HW{!dir.cl_in}}};
endmodule

// File: rtl/pport_chk.sv
module pport_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       rd_ni,
  input logic       wr_ni,
  input logic [1:0] addr_i,
  input logic [7:0] data_i,
  input logic [7:0] data_o,
  input logic [7:0] pa_o,
  input logic [7:0] pa_oe_o,
  input logic [7:0] pb_o,
  input logic [7:0] pb_oe_o,
  input logic [7:0] pc_o,
  input logic [7:0] pc_oe_o
);
  logic mode_wr, bsr_wr;
  assign mode_wr = !cs_ni && !wr_ni && addr_i == 2'b11 && data_i[7];
  assign bsr_wr  = !cs_ni && !wr_ni && addr_i == 2'b11 && !data_i[7];

  p_cs_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(pa_o) && $stable(pb_o) && $stable(pc_o) &&
              $stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o));

  p_mode_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> pa_oe_o == {8{!$past(data_i[4])}} &&
                pb_oe_o == {8{!$past(data_i[1])}} &&
                pc_oe_o == {{4{!$past(data_i[3])}}, {4{!$past(data_i[0])}}});

  p_mode_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> pa_o == 8'h0 && pb_o == 8'h0 && pc_o == 8'h0);

  p_bsr_bit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_wr |=> pc_o[$past(data_i[3:1])] == $past(data_i[0]) &&
               ((pc_o ^ $past(pc_o)) & ~(8'h1 << $past(data_i[3:1]))) == 8'h0);

  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni || addr_i == 2'b11) |-> data_o == 8'h0);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || wr_ni) |=> $stable(pa_o) && $stable(pb_o) && $stable(pc_o));

  p_nibble_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(pc_oe_o[7:4]) inside {0, 4}) && ($countones(pc_oe_o[3:0]) inside {0, 4}));
endmodule

bind pport_top pport_chk u_chk (.*);

// File: tb/pport_top_tb.sv
module pport_top_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0] addr_i = '0;
  logic [7:0] data_i = '0, pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] data_o, pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;

  int errors = 0, checks = 0;
  bit done = 0;

  // model: 1 = input
  bit       m_a_in, m_b_in, m_cu_in, m_cl_in;
  bit [7:0] m_pa, m_pb, m_pc;

  always #5 clk_i = ~clk_i;

  pport_top u_dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] exp_rd(bit [1:0] a);
    case (a)
      2'd0: return m_a_in ? pa_i : m_pa;
      2'd1: return m_b_in ? pb_i : m_pb;
      2'd2: return {m_cu_in ? pc_i[7:4] : m_pc[7:4], m_cl_in ? pc_i[3:0] : m_pc[3:0]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    {m_a_in, m_b_in, m_cu_in, m_cl_in} = 4'hf;
    m_pa = 0; m_pb = 0; m_pc = 0;
  endtask

  task automatic model_write(bit [1:0] a, bit [7:0] d);
    case (a)
      2'd0: m_pa = d;
      2'd1: m_pb = d;
      2'd2: m_pc = d;
      default:
        if (d[7]) begin
          m_a_in = d[4]; m_b_in = d[1]; m_cu_in = d[3]; m_cl_in = d[0];
          m_pa = 0; m_pb = 0; m_pc = 0;
        end else m_pc[d[3:1]] = d[0];
    endcase
  endtask

  task automatic chk_outs(string req);
    chk(req, pa_o, m_pa);
    chk(req, pb_o, m_pb);
    chk(req, pc_o, m_pc);
    chk(req, pa_oe_o, {8{!m_a_in}});
    chk(req, pb_oe_o, {8{!m_b_in}});
    chk(req, pc_oe_o, {{4{!m_cu_in}}, {4{!m_cl_in}}});
  endtask

  // drive at negedge, register at posedge, check at next negedge
  task automatic host_write(bit [1:0] a, bit [7:0] d, bit sel, string req);
    @(negedge clk_i);
    cs_ni = !sel; wr_ni = 1'b0; addr_i = a; data_i = d;
    @(negedge clk_i);
    cs_ni = 1'b1; wr_ni = 1'b1;
    if (sel) model_write(a, d);
    chk_outs(req);
  endtask

  task automatic host_read(bit [1:0] a, bit sel, string req);
    @(negedge clk_i);
    pa_i = 8'($urandom); pb_i = 8'($urandom); pc_i = 8'($urandom);
    cs_ni = !sel; rd_ni = 1'b0; addr_i = a;
    #1;
    chk(req, data_o, sel ? exp_rd(a) : 8'h00);
    cs_ni = 1'b1; rd_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_outs("R1");

    // all inputs: reads track pins
    host_read(2'd0, 1, "R6");
    host_read(2'd1, 1, "R6");
    host_read(2'd2, 1, "R6");
    host_read(2'd3, 1, "R10");
    host_read(2'd0, 0, "R2");

    // A out, B in, C upper out, lower in
    host_write(2'd3, 8'b1000_0011, 1, "R3");
    host_write(2'd0, 8'h5a, 1, "R5");
    host_write(2'd2, 8'hc3, 1, "R5");
    repeat (2) @(negedge clk_i);
    chk_outs("R5");
    host_read(2'd0, 1, "R7");
    host_read(2'd1, 1, "R6");
    host_read(2'd2, 1, "R8");

    // write with chip select high is ignored
    host_write(2'd0, 8'hff, 0, "R2");
    host_write(2'd3, 8'h80, 0, "R2");

    // bit set/reset
    host_write(2'd3, 8'b0000_1011, 1, "R9");
    host_write(2'd3, 8'b0000_1110, 1, "R9");
    host_write(2'd3, 8'b0111_0001, 1, "R9");

    // mode clears latches; bits 6:5 and 2 ignored
    host_write(2'd3, 8'b1110_0100, 1, "R4");
    host_write(2'd3, 8'b1000_1000, 1, "R11");
    host_write(2'd2, 8'h3c, 1, "R11");
    host_write(2'd3, 8'b1110_1100, 1, "R11");
    host_read(2'd2, 1, "R11");

    // lower C out, upper in
    host_write(2'd3, 8'b1000_0001 ^ 8'h09, 1, "R3");
    host_write(2'd2, 8'ha5, 1, "R8");
    host_read(2'd2, 1, "R8");

    for (int i = 0; i < 400; i++) begin
      bit [1:0] a = 2'($urandom);
      bit [7:0] d = 8'($urandom);
      bit sel = ($urandom % 8) != 0;
      if ($urandom % 2) host_write(a, d, sel, d[7] && a == 3 ? "R4" : "R5");
      else host_read(a, sel, a == 3 ? "R10" : "R7");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule